// File: doc/BRIEF.md
# Local Bus Transfer Timeout Monitor

This block watches each transfer that a master starts on the local bus. When software has turned it on, it counts clocks from the start strobe. If no normal acknowledge comes back before the selected limit runs out, it ends the transfer with a one-clock transfer error acknowledge (TEA) pulse to the master. Each timeout also sets a sticky flag, which software clears by writing one.

Transfers headed for the VMEbus are handled by other timers. While such a cycle is flagged, this monitor stays idle. The limit is chosen by a 2-bit code: three finite lengths, measured in microseconds, and a setting that never times out. The `TICKS_PER_US` parameter sets how many clocks make one microsecond.

Top module: `lbus_watch`

## Requirements
- R1: While `tmo_en` is low, `xfer_err` never asserts. A start strobe does not arm the monitor, and an armed transfer is dropped.
- R2: The edge that samples `xfer_start` (with the monitor live) arms it. If no acknowledge is sampled on the next L edges, `xfer_err` is high after the L-th edge.
- R3: L depends on `tmo_sel`. Code 0 gives 8 us, 1 gives 64 us and 2 gives 256 us, each microsecond being `TICKS_PER_US` clocks. Code 3 never times out and drops an armed transfer.
- R4: `xfer_err` is high for exactly one clock. The monitor then stays idle, with no further pulse until a new start.
- R5: An acknowledge sampled while armed ends monitoring, and no `xfer_err` follows it.
- R6: `tmo_flag` sets on the same edge that raises `xfer_err`. It stays high until a clear is written.
- R7: `flag_clr` high on an edge clears `tmo_flag`. If a timeout occurs on that same edge, the flag stays set.
- R8: If an acknowledge is sampled on the very edge where the limit expires, the acknowledge wins and no `xfer_err` is issued.
- R9: While `vme_bound` is high, a start strobe is ignored and an armed transfer is dropped. No `xfer_err` follows.
- R10: After reset, `xfer_err` and `tmo_flag` are low and the monitor is idle.
- R11: A start strobe while already armed restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | One-clock strobe marking the start of a transfer |
| xfer_ack | input | 1 | Normal transfer acknowledge |
| vme_bound | input | 1 | Current cycle is bound for the VMEbus |
| tmo_en | input | 1 | Software enable for the monitor |
| tmo_sel | input | 2 | Timeout select code (see R3) |
| flag_clr | input | 1 | Write-one clear of the sticky flag |
| xfer_err | output | 1 | One-clock transfer error acknowledge to the master |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
The bench measures the exact edge on which the error pulse appears for each limit code. A design that is off by one in its count fires a clock early or late. It places an acknowledge on the expiry edge itself; a design with the wrong priority would issue an error alongside a good acknowledge. It also raises the VMEbus flag or drops the enable in the middle of a transfer, which catches a design that keeps counting and then faults a transfer it does not own. It writes the clear on the edge where a timeout sets the flag, which shows whether a timeout can be lost. Random traffic is compared every clock against a reference model.

// File: rtl/lbus_watch.sv
module lbus_watch #(
  parameter int TICKS_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start,
  input  logic       xfer_ack,
  input  logic       vme_bound,
  input  logic       tmo_en,
  input  logic [1:0] tmo_sel,
  input  logic       flag_clr,
  output logic       xfer_err,
  output logic       tmo_flag
);

  localparam int MAX_TICKS = 256 * TICKS_PER_US;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] LAST0 = CW'(8 * TICKS_PER_US - 1);
  localparam logic [CW-1:0] LAST1 = CW'(64 * TICKS_PER_US - 1);
  localparam logic [CW-1:0] LAST2 = CW'(256 * TICKS_PER_US - 1);

  logic          armed;
  logic [CW-1:0] ticks;
  logic [CW-1:0] last;
  logic          live;
  logic          arm;
  logic          expire;

  assign last = (tmo_sel == 2'd0) ? LAST0 :
                (tmo_sel == 2'd1) ? LAST1 : LAST2;

  assign live   = tmo_en & ~vme_bound & (tmo_sel != 2'd3);
  assign arm    = xfer_start & live;
  assign expire = armed & live & ~xfer_ack & (ticks >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      ticks    <= '0;
      xfer_err <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      xfer_err <= expire;
      tmo_flag <= expire | (tmo_flag & ~flag_clr);
      if (arm) begin
        armed <= 1'b1;
        ticks <= '0;
      end else if (expire | xfer_ack | ~live) begin
        armed <= 1'b0;
      end else if (armed) begin
        ticks <= ticks + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbus_watch_chk.sv
module lbus_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_start,
  input logic       xfer_ack,
  input logic       vme_bound,
  input logic       tmo_en,
  input logic [1:0] tmo_sel,
  input logic       flag_clr,
  input logic       xfer_err,
  input logic       tmo_flag
);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |=> !xfer_err);

  p_never_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == 2'd3) |=> !xfer_err);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  p_ack_silences_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_err);

  p_flag_with_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> tmo_flag);

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> xfer_err);

  p_vme_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vme_bound |=> !xfer_err);

  p_reset_low_r10: assert property (@(posedge clk)
    !rst_n |=> (!xfer_err && !tmo_flag));

endmodule

bind lbus_watch lbus_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
  .vme_bound(vme_bound), .tmo_en(tmo_en), .tmo_sel(tmo_sel),
  .flag_clr(flag_clr), .xfer_err(xfer_err), .tmo_flag(tmo_flag)
);

// File: tb/lbus_watch_bench.sv
`timescale 1ns/1ps
module lbus_watch_bench;
  localparam int TPU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0, xfer_ack = 1'b0, vme_bound = 1'b0;
  logic tmo_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic xfer_err, tmo_flag;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string tag = "R10";

  bit m_busy = 0, m_err = 0, m_flag = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  lbus_watch #(.TICKS_PER_US(TPU)) u_lbus_watch (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
    .vme_bound(vme_bound), .tmo_en(tmo_en), .tmo_sel(tmo_sel),
    .flag_clr(flag_clr), .xfer_err(xfer_err), .tmo_flag(tmo_flag)
  );

  function automatic int lim_of(logic [1:0] s);
    case (s)
      2'd0: return 8 * TPU;
      2'd1: return 64 * TPU;
      2'd2: return 256 * TPU;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit live, fire;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_flag = 0; m_cnt = 0;
    end else begin
      live = tmo_en && !vme_bound && tmo_sel != 2'd3;
      fire = m_busy && live && !xfer_ack && (m_cnt + 1 >= lim_of(tmo_sel));
      m_err = fire;
      if (fire) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (xfer_start && live) begin
        m_busy = 1; m_cnt = 0;
      end else if (fire || xfer_ack || !live) m_busy = 0;
      else if (m_busy) m_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog: act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(string t, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0b exp=%0b at cycle %0d", t, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check({tag, " err"}, xfer_err, m_err);
      check({tag, " flag"}, tmo_flag, m_flag);
    end
  endtask

  task automatic start_xfer();
    xfer_start = 1'b1;
    step(1);
    xfer_start = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed);
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R10 err after reset", xfer_err, 1'b0);
    check("R10 flag after reset", tmo_flag, 1'b0);

    tmo_en = 1'b1;
    for (int s = 0; s < 3; s++) begin
      tag = "R3";
      tmo_sel = 2'(s);
      start_xfer();
      step(lim_of(tmo_sel) - 1);
      check("R2 no err before limit", xfer_err, 1'b0);
      step(1);
      check("R3 err at limit", xfer_err, 1'b1);
      check("R6 flag with err", tmo_flag, 1'b1);
      step(1);
      check("R4 err one clock", xfer_err, 1'b0);
      step(lim_of(tmo_sel) + 4);
      check("R4 idle after err", xfer_err, 1'b0);
      check("R6 flag sticky", tmo_flag, 1'b1);
      clear_flag();
      check("R7 flag cleared", tmo_flag, 1'b0);
    end

    tag = "R3";
    tmo_sel = 2'd3;
    start_xfer();
    step(600);
    check("R3 code 3 never", tmo_flag, 1'b0);

    tag = "R5";
    tmo_sel = 2'd0;
    start_xfer();
    step(5);
    xfer_ack = 1'b1; step(1); xfer_ack = 1'b0;
    step(lim_of(2'd0) + 4);
    check("R5 ack stops timer", tmo_flag, 1'b0);

    tag = "R8";
    start_xfer();
    step(lim_of(2'd0) - 1);
    xfer_ack = 1'b1; step(1); xfer_ack = 1'b0;
    check("R8 ack wins tie", xfer_err, 1'b0);
    step(lim_of(2'd0));
    check("R8 no late err", tmo_flag, 1'b0);

    tag = "R11";
    start_xfer();
    step(10);
    start_xfer();
    step(lim_of(2'd0) - 1);
    check("R11 restart delays err", xfer_err, 1'b0);
    step(1);
    check("R11 err after restart", xfer_err, 1'b1);
    clear_flag();

    tag = "R7";
    start_xfer();
    step(lim_of(2'd0) - 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R7 set beats clear", tmo_flag, 1'b1);
    clear_flag();

    tag = "R1";
    tmo_en = 1'b0;
    start_xfer();
    step(lim_of(2'd0) + 4);
    check("R1 disabled no err", tmo_flag, 1'b0);
    tmo_en = 1'b1;
    start_xfer();
    step(4);
    tmo_en = 1'b0; step(1); tmo_en = 1'b1;
    step(lim_of(2'd0) + 4);
    check("R1 disable drops", tmo_flag, 1'b0);

    tag = "R9";
    vme_bound = 1'b1;
    start_xfer();
    vme_bound = 1'b0;
    step(lim_of(2'd0) + 4);
    check("R9 vme start ignored", tmo_flag, 1'b0);
    start_xfer();
    step(4);
    vme_bound = 1'b1; step(3); vme_bound = 1'b0;
    step(lim_of(2'd0) + 4);
    check("R9 vme drops", tmo_flag, 1'b0);

    tag = "R2 random";
    for (int k = 0; k < 6000; k++) begin
      xfer_start = ($urandom % 40) == 0;
      xfer_ack   = ($urandom % 50) == 0;
      vme_bound  = ($urandom % 60) == 0;
      tmo_en     = ($urandom % 100) != 0;
      flag_clr   = ($urandom % 30) == 0;
      if (($urandom % 200) == 0) tmo_sel = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
      step(1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule